// File: doc/BRIEF.md
# Per-Channel Hit Time Offset Corrector

This block sits inline on a 32-bit readout word stream. Each word carries a 4-bit type flag, a 9-bit channel number and a 19-bit measurement field. When a word is a leading-edge or trailing-edge hit, the block reads a calibration offset for that channel from a small RAM and adds it to the measurement. Any other word, such as a timestamp or a footer, passes through bit for bit. A configuration host loads the offsets through a simple write port, so each channel can be trimmed on its own.

A strobe marks the valid words on both sides. Every accepted word leaves the block exactly four clock cycles after it enters. Idle cycles in the input strobe reappear at the output in the same positions. Only the pipeline valid bits are reset. The offset RAM keeps its contents through a reset, and the host must load every channel it uses.

Top module: `hit_time_trim`

## Requirements
- R1: The word layout is fixed: the type flag is bits 31:28, the channel is bits 27:19 and the measurement is bits 18:0.
- R2: A word with flag 0x4 (leading hit) or 0x5 (trailing hit) leaves with measurement = (input measurement + offset of its channel) modulo 2^19.
- R3: A word with any flag other than 0x4 or 0x5 (0xA timestamp, 0xB footer and all other codes) leaves with all 32 bits unchanged.
- R4: On hit words, bits 31:19 (flag and channel) are copied to the output unchanged.
- R5: out_vld in a cycle equals in_vld four cycles earlier, so each accepted word appears after exactly 4 clock cycles and input bubbles are kept.
- R6: The 13-bit offset is a two's-complement value, sign-extended to 19 bits before it is added. For example, 0x1FFF subtracts 1 and 0x1000 subtracts 4096.
- R7: When cfg_we is high at a rising edge, cfg_data is stored as the offset of channel cfg_addr, and later hits on that channel use the new value.
- R8: When rst_n is low at a rising edge, all pipeline valid bits clear. out_vld is low after that edge, and no word that entered before the reset is ever emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input word strobe |
| in_word | input | 32 | Input stream word |
| cfg_we | input | 1 | Offset RAM write enable |
| cfg_addr | input | 9 | Offset RAM channel address |
| cfg_data | input | 13 | Signed offset to store |
| out_vld | output | 1 | Output word strobe |
| out_word | output | 32 | Corrected output word |

## Verification
The assertions check on every cycle the four-cycle alignment between the input strobe and the output strobe. They also check that non-hit words come out bit-identical, that the flag and channel of hit words are untouched, and that reset removes all valid output. The actual offset arithmetic can only be shown by the bench scenarios, because it depends on RAM contents loaded by the host. These scenarios cover sign extension at both offset extremes, wraparound of the measurement field, a rewrite of a channel's offset, and a stream with periodic bubbles.

// File: rtl/htt_pkg.sv
// Shared constants and helpers for the hit time trim block.
// Assumes the fixed 32-bit word layout: flag | channel | measurement.
package htt_pkg;
    localparam int FLAG_W = 4;
    localparam logic [FLAG_W-1:0] FLAG_LEAD  = 4'h4;
    localparam logic [FLAG_W-1:0] FLAG_TRAIL = 4'h5;
    localparam logic [FLAG_W-1:0] FLAG_TSTMP = 4'hA;
    localparam logic [FLAG_W-1:0] FLAG_FOOT  = 4'hB;

    // True when the flag marks a time measurement that receives an offset.
    function automatic logic flag_is_hit(input logic [FLAG_W-1:0] f);
        return (f == FLAG_LEAD) || (f == FLAG_TRAIL);
    endfunction
endpackage

// File: rtl/htt_field_split.sv
// Splits a stream word into its fields and classifies it.
// Purely combinational; the field widths come from parameters.
module htt_field_split
    import htt_pkg::*;
#(
    parameter int CH_W   = 9,
    parameter int MEAS_W = 19,
    localparam int WORD_W = FLAG_W + CH_W + MEAS_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [FLAG_W-1:0] flag,
    output logic [CH_W-1:0]   chan,
    output logic [MEAS_W-1:0] meas,
    output logic              is_hit
);
    // Field extraction and hit classification.
    always_comb begin
        flag   = word[WORD_W-1 -: FLAG_W];
        chan   = word[MEAS_W +: CH_W];
        meas   = word[MEAS_W-1:0];
        is_hit = flag_is_hit(flag);
    end
endmodule

// File: rtl/htt_offset_ram.sv
// One-write, one-read offset memory with one entry per channel.
// The read is registered. A read and a write to the same address in the
// same cycle return the old contents. The contents are not reset.
module htt_offset_ram #(
    parameter int CH_W  = 9,
    parameter int OFS_W = 13,
    localparam int DEPTH = 1 << CH_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [CH_W-1:0]  waddr,
    input  logic [OFS_W-1:0] wdata,
    input  logic [CH_W-1:0]  raddr,
    output logic [OFS_W-1:0] rdata
);
    logic [OFS_W-1:0] mem [DEPTH];

    // Host write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port (read-before-write).
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/htt_trim_add.sv
// Registered correction stage: adds the sign-extended offset to the
// measurement of hit words and passes every other word through.
// Assumes MEAS_W > OFS_W. The sum wraps within the measurement field.
module htt_trim_add
    import htt_pkg::*;
#(
    parameter int CH_W   = 9,
    parameter int MEAS_W = 19,
    parameter int OFS_W  = 13,
    localparam int WORD_W = FLAG_W + CH_W + MEAS_W,
    localparam int EXT_W  = MEAS_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              hit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic              vld_o,
    output logic [WORD_W-1:0] word_o
);
    logic [MEAS_W-1:0] ofs_ext;
    logic [MEAS_W-1:0] meas_sum;
    logic [WORD_W-1:0] word_nx;

    // Sign extension of the offset and the wrapped sum.
    always_comb begin
        ofs_ext  = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
        meas_sum = word_i[MEAS_W-1:0] + ofs_ext;
        word_nx  = hit_i ? {word_i[WORD_W-1:MEAS_W], meas_sum} : word_i;
    end

    // Valid bit register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Data register; holds its value through bubbles.
    always_ff @(posedge clk) begin
        if (vld_i) word_o <= word_nx;
    end
endmodule

// File: rtl/hit_time_trim.sv
// Top of the per-channel hit time offset corrector.
// Pipeline: s1 captures the input and issues the RAM read, s2 waits for
// the registered RAM data, s3 adds, s4 drives the outputs. Latency is 4.
// Only valid bits are reset. The offset RAM is loaded by the host.
module hit_time_trim
    import htt_pkg::*;
#(
    parameter int CH_W   = 9,
    parameter int MEAS_W = 19,
    parameter int OFS_W  = 13,
    localparam int WORD_W = FLAG_W + CH_W + MEAS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_addr,
    input  logic [OFS_W-1:0]  cfg_data,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word
);
    logic [FLAG_W-1:0] in_flag;
    logic [CH_W-1:0]   in_chan;
    logic [MEAS_W-1:0] in_meas;
    logic              in_hit;

    logic              s1_vld, s2_vld, s3_vld, s4_vld;
    logic              s1_hit, s2_hit;
    logic [WORD_W-1:0] s1_word, s2_word, s3_word, s4_word;
    logic [OFS_W-1:0]  ram_q;

    htt_field_split #(.CH_W(CH_W), .MEAS_W(MEAS_W)) u_split (
        .word   (in_word),
        .flag   (in_flag),
        .chan   (in_chan),
        .meas   (in_meas),
        .is_hit (in_hit)
    );

    // Stage 1 valid: capture the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_vld <= 1'b0;
        else        s1_vld <= in_vld;
    end

    // Stage 1 data: capture the word and its classification.
    always_ff @(posedge clk) begin
        if (in_vld) begin
            s1_word <= in_word;
            s1_hit  <= in_hit;
        end
    end

    htt_offset_ram #(.CH_W(CH_W), .OFS_W(OFS_W)) u_ram (
        .clk   (clk),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (s1_word[MEAS_W +: CH_W]),
        .rdata (ram_q)
    );

    // Stage 2 valid: align with the registered RAM output.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_vld <= 1'b0;
        else        s2_vld <= s1_vld;
    end

    // Stage 2 data: carry the word alongside the RAM read.
    always_ff @(posedge clk) begin
        if (s1_vld) begin
            s2_word <= s1_word;
            s2_hit  <= s1_hit;
        end
    end

    htt_trim_add #(.CH_W(CH_W), .MEAS_W(MEAS_W), .OFS_W(OFS_W)) u_add (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (s2_vld),
        .hit_i  (s2_hit),
        .word_i (s2_word),
        .ofs_i  (ram_q),
        .vld_o  (s3_vld),
        .word_o (s3_word)
    );

    // Stage 4 valid: output strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) s4_vld <= 1'b0;
        else        s4_vld <= s3_vld;
    end

    // Stage 4 data: output word register.
    always_ff @(posedge clk) begin
        if (s3_vld) s4_word <= s3_word;
    end

    assign out_vld  = s4_vld;
    assign out_word = s4_word;

    // Unused split fields are kept for readability of the decode.
    logic unused_fields;
    assign unused_fields = ^{in_flag, in_chan, in_meas};
endmodule

// File: rtl/htt_checker.sv
// Cycle-level properties of hit_time_trim, bound to the top module.
// A saturating counter of cycles since reset gates the 4-deep looks back.
module htt_checker
    import htt_pkg::*;
#(
    parameter int CH_W   = 9,
    parameter int MEAS_W = 19,
    parameter int OFS_W  = 13,
    localparam int WORD_W = FLAG_W + CH_W + MEAS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [WORD_W-1:0] in_word,
    input logic              out_vld,
    input logic [WORD_W-1:0] out_word
);
    logic [2:0] since_rst;

    // Counts cycles since reset, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 3'd0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R5: output strobe is the input strobe four cycles later.
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (out_vld == $past(in_vld, 4)));

    // R3: non-hit words leave unchanged.
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && out_vld && $past(in_vld, 4)
         && !flag_is_hit($past(in_word[WORD_W-1 -: FLAG_W], 4)))
        |-> (out_word == $past(in_word, 4)));

    // R4: flag and channel of hit words are preserved.
    p_header_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && out_vld && $past(in_vld, 4))
        |-> (out_word[WORD_W-1:MEAS_W] == $past(in_word[WORD_W-1:MEAS_W], 4)));

    // R8: a reset edge leaves the output strobe low.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> !out_vld);
endmodule

bind hit_time_trim htt_checker #(.CH_W(CH_W), .MEAS_W(MEAS_W), .OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_word  (in_word),
    .out_vld  (out_vld),
    .out_word (out_word)
);

// File: tb/sim_hit_time_trim.sv
// Self-checking bench: a vector table walked by one loop (twice, dense and
// with bubbles), then directed tests for offset rewrite and reset.
module sim_hit_time_trim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_word = '0;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [12:0] cfg_data = '0;
    logic        out_vld;
    logic [31:0] out_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hit_time_trim u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_vld(out_vld), .out_word(out_word)
    );

    // {input word, expected output word}. Layout per R1: flag 31:28, ch 27:19.
    // Offsets: ch0 +5, ch1 -1 (0x1FFF), ch2 +4095, ch3 -4096 (0x1000), ch5 0, ch511 +0x123.
    localparam int NV = 11;
    localparam logic [63:0] VEC [NV] = '{
        {32'h40000010, 32'h40000015},  // R2 lead ch0
        {32'h5007FFFE, 32'h50000003},  // R2 trail ch0, wraps
        {32'h40080100, 32'h400800FF},  // R6 ch1 minus one
        {32'h40080000, 32'h400FFFFF},  // R6 ch1 wraps below zero, R4 header
        {32'h50100001, 32'h50101000},  // R6 ch2 largest positive
        {32'h40182000, 32'h40181000},  // R6 ch3 most negative
        {32'h5FF92345, 32'h5FF92468},  // R2 ch511
        {32'hA1234567, 32'hA1234567},  // R3 timestamp
        {32'hB00000FF, 32'hB00000FF},  // R3 footer
        {32'h60000010, 32'h60000010},  // R3 other flag
        {32'h40280077, 32'h40280077}   // R2 zero offset ch5
    };

    function automatic string tag_of(input logic [31:0] w);
        return (w[31:28] == 4'h4 || w[31:28] == 4'h5) ? "R2/R6" : "R3";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [8:0] a, input logic [12:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Walk the table; with bubbles, every third slot is idle (R5).
    task automatic run_table(input bit bubbles);
        for (int i = 0; i < NV + 4; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                int j = i - 4;
                logic ev = bubbles ? (j % 3 != 1) : 1'b1;
                check("R5 strobe", {31'd0, out_vld}, {31'd0, ev});
                if (ev) check(tag_of(VEC[j][63:32]), out_word, VEC[j][31:0]);
            end
            if (i < NV) begin
                in_vld  = bubbles ? (i % 3 != 1) : 1'b1;
                in_word = VEC[i][63:32];
            end else begin
                in_vld = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset strobe", {31'd0, out_vld}, 32'd0);
        rst_n = 1'b1;
        // R7: load offsets through the host port.
        cfg_write(9'd0,   13'h0005);
        cfg_write(9'd1,   13'h1FFF);
        cfg_write(9'd2,   13'h0FFF);
        cfg_write(9'd3,   13'h1000);
        cfg_write(9'd5,   13'h0000);
        cfg_write(9'd511, 13'h0123);

        run_table(1'b0);
        run_table(1'b1);

        // R7: rewrite ch0 and check the new offset is applied.
        cfg_write(9'd0, 13'h0100);
        @(negedge clk);
        in_vld = 1'b1; in_word = 32'h40000010;
        @(negedge clk);
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 strobe", {31'd0, out_vld}, 32'd1);
        check("R7 rewrite", out_word, 32'h40000110);

        // R8: reset with words in flight; none must emerge.
        @(negedge clk);
        in_vld = 1'b1; in_word = 32'hA0000001;
        @(negedge clk);
        in_word = 32'hA0000002;
        @(negedge clk);
        in_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            check("R8 flush", {31'd0, out_vld}, 32'd0);
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule